// File: doc/BRIEF.md
# Halfword Load Unit with Fault Checks

This block executes the memory stage of a zero-extending 16-bit load for a 32-bit big-endian processor. It takes two operand values and forms an effective address from them. Normally it adds them. In the extended form it joins them into a wider address. It then checks the operation against three fault sources in a fixed order. The first is a translation miss, which only counts in virtual mode. The second is a page protection fault, which only counts in user mode under virtual mode. The third is a misaligned address. The translation and protection results come from outside the block as per-operation flags.

A fault-free operation reads one 32-bit word from a synchronous memory port. The block picks the two bytes of the halfword from that word and orders them by a rule that depends on virtual mode, a reversed-load flag and a per-page endian flag. It then writes the zero-extended result back to the destination register.

A faulting operation writes nothing back. Instead the block produces a single exception pulse and updates a set of held exception fields: a cause code, the data-storage bit, the faulting register index and the saved mode bits. For translation and protection faults it also tells the status logic to clear the live user and virtual mode bits. A parameter selects one of two configurations. The normal one delivers the result one cycle after the operation. The area-optimized one registers the operands first and takes two cycles.

Top module: `hload_unit`

## Requirements
- R1: With op_ext=0 the byte address is (op_a+op_b) mod 2^32, zero-extended to AW=32+XW bits. With op_ext=1 the byte address is {op_a[XW-1:0], op_b}. For a fault-free operation mem_rd_en is 1 for one cycle and mem_addr carries the byte address with its two least significant bits cleared. A faulting operation raises no mem_rd_en.
- R2: When mode_vm=1 and pg_tlb_miss=1, the operation faults with exc_code 5'b10010. This fault has the highest priority. pg_tlb_miss has no effect while mode_vm=0.
- R3: When mode_um=1, mode_vm=1 and pg_prot_fault=1, and no R2 fault is present, the operation faults with exc_code 5'b10000 and exc_diz becomes 1. pg_prot_fault has no effect unless both mode bits are 1.
- R4: On an R2 or R3 fault, exc_mode_upd becomes 1, exc_ums takes mode_um and exc_vms takes mode_vm. This instructs the status logic to clear the live user and virtual mode bits.
- R5: When the least significant address bit is 1 and no R2 or R3 fault is present, the operation faults with exc_code 5'b00001. exc_rx takes op_rd and exc_mode_upd becomes 0. exc_s and exc_w are 0, and exc_diz, exc_ums and exc_vms keep their values.
- R6: The byte at the address A goes to wb_data[15:8] and the byte at A+1 goes to wb_data[7:0] in three cases. These are: mode_vm=0 with op_rev=1; mode_vm=1 with op_rev=1 and pg_le=1; and mode_vm=1 with op_rev=0 and pg_le=0. In every other case the two bytes are exchanged. The memory word is big-endian: the byte at word offset k is mem_rdata[31-8k -: 8].
- R7: wb_data[31:16] is 0 whenever wb_valid is 1.
- R8: A fault-free operation gives exactly one wb_valid cycle with wb_rd=op_rd. A faulting operation gives no wb_valid.
- R9: With AREA_OPT=0, the memory read is issued in the cycle the operation is presented and the result (wb_valid or exc_valid) appears one cycle later. With AREA_OPT=1 both events are one cycle later than that.
- R10: A faulting operation gives exactly one exc_valid cycle. The exception fields change only at that point and hold their values until the next fault. After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Load operation presented this cycle |
| op_a | input | 32 | First source operand |
| op_b | input | 32 | Second source operand |
| op_ext | input | 1 | Extended address form: join operands instead of adding them |
| op_rev | input | 1 | Reversed-byte-order load |
| op_rd | input | RIDX_W | Destination register index |
| mode_um | input | 1 | Live user-mode bit |
| mode_vm | input | 1 | Live virtual-mode bit |
| pg_tlb_miss | input | 1 | Translation miss for this address |
| pg_prot_fault | input | 1 | Protection violation for this address |
| pg_le | input | 1 | Page is marked little-endian |
| mem_rd_en | output | 1 | Memory word read request |
| mem_addr | output | AW | Word-aligned byte address of the read |
| mem_rdata | input | 32 | Read data, valid one cycle after the request |
| wb_valid | output | 1 | Register writeback strobe |
| wb_rd | output | RIDX_W | Writeback register index |
| wb_data | output | 32 | Zero-extended halfword |
| exc_valid | output | 1 | One-cycle exception pulse |
| exc_code | output | 5 | Held exception cause code |
| exc_s | output | 1 | Held store-access bit (always 0 for loads) |
| exc_diz | output | 1 | Held data-storage bit |
| exc_w | output | 1 | Held word-access bit (0 marks a halfword) |
| exc_rx | output | RIDX_W | Held faulting destination index |
| exc_mode_upd | output | 1 | Last fault saves and clears the mode bits |
| exc_ums | output | 1 | Saved user-mode bit |
| exc_vms | output | 1 | Saved virtual-mode bit |

## Verification
If the fault priority is evaluated in the wrong order, exc_code shows the wrong cause in the same cycle as the pulse, one or two cycles after the operation. A lost or stale lane-select or swap flag shows up as an exchanged or misplaced byte on wb_data in that same result cycle. A held field that is updated when it should not be, such as exc_diz or exc_rx on an unrelated fault, stays wrong at the ports until the next fault. It is therefore visible on the very next response of any kind. A stage register in the area-optimized path that is clocked at the wrong moment moves the memory request or the result by a cycle. That shows up against the expected cycle at once.

// File: rtl/hload_pkg.sv
package hload_pkg;
  typedef enum logic [4:0] {
    EXC_NONE  = 5'b00000,
    EXC_ALIGN = 5'b00001,
    EXC_PROT  = 5'b10000,
    EXC_TLB   = 5'b10010
  } exc_code_e;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/hload_agen.sv
module hload_agen #(
  parameter int unsigned XW = 16,
  localparam int unsigned AW = hload_pkg::WORD_W + XW
) (
  input  logic [hload_pkg::WORD_W-1:0] src_a,
  input  logic [hload_pkg::WORD_W-1:0] src_b,
  input  logic                         join_en,
  output logic [AW-1:0]                byte_addr
);
  logic [hload_pkg::WORD_W-1:0] sum;

  // Sum wraps modulo 2^32; the extended form joins the operands.
  assign sum       = src_a + src_b;
  assign byte_addr = join_en ? {src_a[XW-1:0], src_b} : {{XW{1'b0}}, sum};
endmodule

// File: rtl/hload_fault.sv
module hload_fault
  import hload_pkg::*;
(
  input  logic      um,
  input  logic      vm,
  input  logic      tlb_miss,
  input  logic      prot_fault,
  input  logic      addr_lsb,
  output exc_code_e code,
  output logic      any_fault,
  output logic      mode_fault
);
  logic tlb_hit, prot_hit;

  assign tlb_hit  = vm & tlb_miss;
  assign prot_hit = ~tlb_hit & um & vm & prot_fault;

  always_comb begin
    if (tlb_hit)       code = EXC_TLB;
    else if (prot_hit) code = EXC_PROT;
    else if (addr_lsb) code = EXC_ALIGN;
    else               code = EXC_NONE;
  end

  assign any_fault  = (code != EXC_NONE);
  assign mode_fault = tlb_hit | prot_hit;
endmodule

// File: rtl/hload_lane.sv
module hload_lane
  import hload_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic              upper_half_n,
  input  logic              keep_order,
  output logic [WORD_W-1:0] result
);
  logic [BYTE_W-1:0] at_addr, at_next;

  // upper_half_n = address bit 1: 0 selects offsets 0/1, 1 selects offsets 2/3.
  assign at_addr = upper_half_n ? word[15:8] : word[31:24];
  assign at_next = upper_half_n ? word[7:0]  : word[23:16];
  assign result  = {{(WORD_W-2*BYTE_W){1'b0}},
                    keep_order ? {at_addr, at_next} : {at_next, at_addr}};
endmodule

// File: rtl/hload_unit.sv
module hload_unit
  import hload_pkg::*;
#(
  parameter int unsigned XW       = 16,
  parameter int unsigned RIDX_W   = 5,
  parameter bit          AREA_OPT = 1'b0,
  localparam int unsigned AW      = WORD_W + XW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [31:0]       op_a,
  input  logic [31:0]       op_b,
  input  logic              op_ext,
  input  logic              op_rev,
  input  logic [RIDX_W-1:0] op_rd,
  input  logic              mode_um,
  input  logic              mode_vm,
  input  logic              pg_tlb_miss,
  input  logic              pg_prot_fault,
  input  logic              pg_le,
  output logic              mem_rd_en,
  output logic [AW-1:0]     mem_addr,
  input  logic [31:0]       mem_rdata,
  output logic              wb_valid,
  output logic [RIDX_W-1:0] wb_rd,
  output logic [31:0]       wb_data,
  output logic              exc_valid,
  output logic [4:0]        exc_code,
  output logic              exc_s,
  output logic              exc_diz,
  output logic              exc_w,
  output logic [RIDX_W-1:0] exc_rx,
  output logic              exc_mode_upd,
  output logic              exc_ums,
  output logic              exc_vms
);
  typedef struct packed {
    logic [31:0]       a;
    logic [31:0]       b;
    logic              ext;
    logic              rev;
    logic [RIDX_W-1:0] rd;
    logic              um;
    logic              vm;
    logic              tlb;
    logic              prot;
    logic              le;
  } op_pay_t;

  op_pay_t in_pay, st_pay;
  logic    st_vld;

  assign in_pay = '{a: op_a, b: op_b, ext: op_ext, rev: op_rev, rd: op_rd,
                    um: mode_um, vm: mode_vm, tlb: pg_tlb_miss,
                    prot: pg_prot_fault, le: pg_le};

  // Optional operand stage for the area-optimized configuration (R9).
  generate
    if (AREA_OPT) begin : g_stage
      op_pay_t pay_q;
      logic    vld_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q <= 1'b0;
          pay_q <= '0;
        end else begin
          vld_q <= op_valid;
          if (op_valid) pay_q <= in_pay;
        end
      end
      assign st_vld = vld_q;
      assign st_pay = pay_q;
    end else begin : g_direct
      assign st_vld = op_valid;
      assign st_pay = in_pay;
    end
  endgenerate

  logic [AW-1:0] ea;
  exc_code_e     f_code;
  logic          f_any, f_mode;
  logic          keep_order;

  hload_agen #(.XW(XW)) agen_i (
    .src_a(st_pay.a), .src_b(st_pay.b), .join_en(st_pay.ext), .byte_addr(ea)
  );

  hload_fault fault_i (
    .um(st_pay.um), .vm(st_pay.vm), .tlb_miss(st_pay.tlb),
    .prot_fault(st_pay.prot), .addr_lsb(ea[0]),
    .code(f_code), .any_fault(f_any), .mode_fault(f_mode)
  );

  assign keep_order = (~st_pay.vm & st_pay.rev)
                    | ( st_pay.vm & st_pay.rev & st_pay.le)
                    | ( st_pay.vm & ~st_pay.rev & ~st_pay.le);

  assign mem_rd_en = st_vld & ~f_any;
  assign mem_addr  = {ea[AW-1:2], 2'b00};

  // Response bookkeeping: next-state logic
  logic              ok_d, ok_q, xv_d, xv_q;
  logic              hsel_q, keep_q;
  logic [RIDX_W-1:0] rd_q;
  exc_code_e         code_d, code_q;
  logic              diz_d, diz_q, upd_d, upd_q, ums_d, ums_q, vms_d, vms_q;
  logic [RIDX_W-1:0] rx_d, rx_q;

  always_comb begin
    ok_d   = st_vld & ~f_any;
    xv_d   = st_vld & f_any;
    code_d = code_q;
    diz_d  = diz_q;
    rx_d   = rx_q;
    upd_d  = upd_q;
    ums_d  = ums_q;
    vms_d  = vms_q;
    if (xv_d) begin
      code_d = f_code;
      upd_d  = f_mode;
      if (f_mode) begin
        ums_d = st_pay.um;
        vms_d = st_pay.vm;
      end
      if (f_code == EXC_PROT)  diz_d = 1'b1;
      if (f_code == EXC_ALIGN) rx_d  = st_pay.rd;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q   <= 1'b0;
      xv_q   <= 1'b0;
      hsel_q <= 1'b0;
      keep_q <= 1'b0;
      rd_q   <= '0;
      code_q <= EXC_NONE;
      diz_q  <= 1'b0;
      rx_q   <= '0;
      upd_q  <= 1'b0;
      ums_q  <= 1'b0;
      vms_q  <= 1'b0;
    end else begin
      ok_q <= ok_d;
      xv_q <= xv_d;
      if (ok_d) begin
        hsel_q <= ea[1];
        keep_q <= keep_order;
        rd_q   <= st_pay.rd;
      end
      if (xv_d) begin
        code_q <= code_d;
        diz_q  <= diz_d;
        rx_q   <= rx_d;
        upd_q  <= upd_d;
        ums_q  <= ums_d;
        vms_q  <= vms_d;
      end
    end
  end

  hload_lane lane_i (
    .word(mem_rdata), .upper_half_n(hsel_q), .keep_order(keep_q), .result(wb_data)
  );

  assign wb_valid     = ok_q;
  assign wb_rd        = rd_q;
  assign exc_valid    = xv_q;
  assign exc_code     = code_q;
  assign exc_s        = 1'b0;  // loads never set the store bit
  assign exc_w        = 1'b0;  // halfword access
  assign exc_diz      = diz_q;
  assign exc_rx       = rx_q;
  assign exc_mode_upd = upd_q;
  assign exc_ums      = ums_q;
  assign exc_vms      = vms_q;
endmodule

// File: rtl/hload_unit_chk.sv
module hload_unit_chk
  import hload_pkg::*;
#(
  parameter int unsigned RIDX_W   = 5,
  parameter bit          AREA_OPT = 1'b0,
  parameter int unsigned AW       = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic              mem_rd_en,
  input logic [AW-1:0]     mem_addr,
  input logic              wb_valid,
  input logic [31:0]       wb_data,
  input logic              exc_valid,
  input logic [4:0]        exc_code,
  input logic              exc_diz,
  input logic [RIDX_W-1:0] exc_rx,
  input logic              exc_mode_upd,
  input logic              exc_ums,
  input logic              exc_vms
);
  localparam int unsigned LAT = AREA_OPT ? 2 : 1;

  assert_no_dual_resp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wb_valid && exc_valid));

  assert_read_then_wb_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> wb_valid);

  assert_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_data[31:16] == 16'h0000));

  assert_fields_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_valid |-> $stable({exc_code, exc_diz, exc_rx, exc_mode_upd, exc_ums, exc_vms}));

  assert_known_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (exc_code == EXC_TLB || exc_code == EXC_PROT || exc_code == EXC_ALIGN));

  assert_mode_save_R4: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (exc_mode_upd == (exc_code != EXC_ALIGN)));

  assert_prot_diz_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && exc_code == EXC_PROT) |-> exc_diz);

  assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid || exc_valid) |-> $past(op_valid, LAT));
endmodule

bind hload_unit hload_unit_chk #(.RIDX_W(RIDX_W), .AREA_OPT(AREA_OPT), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .mem_rd_en(mem_rd_en),
  .mem_addr(mem_addr), .wb_valid(wb_valid), .wb_data(wb_data),
  .exc_valid(exc_valid), .exc_code(exc_code), .exc_diz(exc_diz),
  .exc_rx(exc_rx), .exc_mode_upd(exc_mode_upd), .exc_ums(exc_ums),
  .exc_vms(exc_vms)
);

// File: tb/hload_unit_tb_top.sv
`timescale 1ns/1ps
module hload_unit_tb_top;
  localparam int XW = 16;
  localparam int RW = 5;
  localparam int AW = 32 + XW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          op_valid = 1'b0, op_ext = 1'b0, op_rev = 1'b0;
  logic [31:0]   op_a = '0, op_b = '0;
  logic [RW-1:0] op_rd = '0;
  logic          mode_um = 1'b0, mode_vm = 1'b0;
  logic          pg_tlb = 1'b0, pg_prot = 1'b0, pg_le = 1'b0;

  logic          rd_en [2];
  logic [AW-1:0] maddr [2];
  logic [31:0]   rdata [2];
  logic          wbv   [2];
  logic [RW-1:0] wbrd  [2];
  logic [31:0]   wbd   [2];
  logic          xv    [2];
  logic [4:0]    xcode [2];
  logic          xs [2], xdiz [2], xw [2], xupd [2], xums [2], xvms [2];
  logic [RW-1:0] xrx   [2];

  int nchk = 0, nerr = 0;
  bit done = 1'b0;

  function automatic logic [31:0] mem_word(input logic [AW-1:0] a);
    logic [31:0] lo;
    lo = a[31:0];
    return (lo * 32'h9E3779B1) ^ {16'h0, a[AW-1:32]} ^ 32'h3C6EF372;
  endfunction

  function automatic logic [7:0] mem_byte(input logic [AW-1:0] a);
    logic [31:0] w;
    w = mem_word({a[AW-1:2], 2'b00});
    return w[8*(3 - a[1:0]) +: 8];
  endfunction

  hload_unit #(.XW(XW), .RIDX_W(RW), .AREA_OPT(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_a(op_a), .op_b(op_b),
    .op_ext(op_ext), .op_rev(op_rev), .op_rd(op_rd), .mode_um(mode_um),
    .mode_vm(mode_vm), .pg_tlb_miss(pg_tlb), .pg_prot_fault(pg_prot), .pg_le(pg_le),
    .mem_rd_en(rd_en[0]), .mem_addr(maddr[0]), .mem_rdata(rdata[0]),
    .wb_valid(wbv[0]), .wb_rd(wbrd[0]), .wb_data(wbd[0]), .exc_valid(xv[0]),
    .exc_code(xcode[0]), .exc_s(xs[0]), .exc_diz(xdiz[0]), .exc_w(xw[0]),
    .exc_rx(xrx[0]), .exc_mode_upd(xupd[0]), .exc_ums(xums[0]), .exc_vms(xvms[0])
  );

  hload_unit #(.XW(XW), .RIDX_W(RW), .AREA_OPT(1'b1)) dut_a_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_a(op_a), .op_b(op_b),
    .op_ext(op_ext), .op_rev(op_rev), .op_rd(op_rd), .mode_um(mode_um),
    .mode_vm(mode_vm), .pg_tlb_miss(pg_tlb), .pg_prot_fault(pg_prot), .pg_le(pg_le),
    .mem_rd_en(rd_en[1]), .mem_addr(maddr[1]), .mem_rdata(rdata[1]),
    .wb_valid(wbv[1]), .wb_rd(wbrd[1]), .wb_data(wbd[1]), .exc_valid(xv[1]),
    .exc_code(xcode[1]), .exc_s(xs[1]), .exc_diz(xdiz[1]), .exc_w(xw[1]),
    .exc_rx(xrx[1]), .exc_mode_upd(xupd[1]), .exc_ums(xums[1]), .exc_vms(xvms[1])
  );

  // Synchronous memory models
  always @(posedge clk) begin
    if (rd_en[0]) rdata[0] <= mem_word(maddr[0]);
    if (rd_en[1]) rdata[1] <= mem_word(maddr[1]);
  end

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Bench model of held exception fields
  logic [4:0]    m_code = 5'd0;
  logic          m_diz = 1'b0, m_upd = 1'b0, m_ums = 1'b0, m_vms = 1'b0;
  logic [RW-1:0] m_rx = '0;

  task automatic chk_resp(input int d, input string note, input logic ok,
                          input logic [RW-1:0] rd, input logic [31:0] data,
                          input string code_req);
    string tg;
    tg = $sformatf("dut%0d %s", d, note);
    chk("R8", {tg, " wb_valid"}, wbv[d], ok);
    chk("R10", {tg, " exc_valid"}, xv[d], !ok);
    if (ok) begin
      chk("R8", {tg, " wb_rd"}, wbrd[d], rd);
      chk("R7", {tg, " wb_data upper"}, wbd[d][31:16], 16'h0);
      chk("R6", {tg, " wb_data halfword"}, wbd[d][15:0], data[15:0]);
    end
    chk(code_req, {tg, " exc_code"}, xcode[d], m_code);
    chk("R3", {tg, " exc_diz"}, xdiz[d], m_diz);
    chk("R5", {tg, " exc_rx"}, xrx[d], m_rx);
    chk("R5", {tg, " exc_s/exc_w"}, {xs[d], xw[d]}, 2'b00);
    chk("R4", {tg, " mode save"}, {xupd[d], xums[d], xvms[d]}, {m_upd, m_ums, m_vms});
  endtask

  task automatic do_op(input logic [31:0] a, input logic [31:0] b, input logic ext,
                       input logic rev, input logic [RW-1:0] rd, input logic um,
                       input logic vm, input logic tlb, input logic prot,
                       input logic le, input string note);
    logic [AW-1:0] ea;
    logic tf, pf, af, ok, keep;
    logic [31:0] exp_data;
    logic [31:0] s;
    string creq;
    s  = a + b;
    ea = ext ? {a[XW-1:0], b} : {{XW{1'b0}}, s};
    tf = vm & tlb;
    pf = !tf & um & vm & prot;
    af = !tf & !pf & ea[0];
    ok = !(tf | pf | af);
    keep = (!vm & rev) | (vm & rev & le) | (vm & !rev & !le);
    exp_data = keep ? {16'h0, mem_byte(ea), mem_byte(ea + 1)}
                    : {16'h0, mem_byte(ea + 1), mem_byte(ea)};
    creq = tf ? "R2" : pf ? "R3" : af ? "R5" : "R10";
    if (!ok) begin
      m_code = tf ? 5'b10010 : pf ? 5'b10000 : 5'b00001;
      m_upd  = tf | pf;
      if (tf | pf) begin m_ums = um; m_vms = vm; end
      if (pf) m_diz = 1'b1;
      if (af) m_rx = rd;
    end
    @(negedge clk);
    op_valid = 1'b1; op_a = a; op_b = b; op_ext = ext; op_rev = rev; op_rd = rd;
    mode_um = um; mode_vm = vm; pg_tlb = tlb; pg_prot = prot; pg_le = le;
    #1;
    chk("R1", {note, " dut0 rd_en"}, rd_en[0], ok);
    if (ok) chk("R1", {note, " dut0 mem_addr"}, maddr[0], {ea[AW-1:2], 2'b00});
    chk("R9", {note, " dut1 early read"}, rd_en[1], 1'b0);
    @(negedge clk);
    op_valid = 1'b0;
    #1;
    chk_resp(0, note, ok, rd, exp_data, creq);
    chk("R9", {note, " dut1 rd_en"}, rd_en[1], ok);
    if (ok) chk("R1", {note, " dut1 mem_addr"}, maddr[1], {ea[AW-1:2], 2'b00});
    chk("R9", {note, " dut1 early result"}, {wbv[1], xv[1]}, 2'b00);
    @(negedge clk);
    #1;
    chk_resp(1, note, ok, rd, exp_data, creq);
    chk("R10", {note, " dut0 one-cycle response"}, {wbv[0], xv[0]}, 2'b00);
  endtask

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    for (int d = 0; d < 2; d++) begin
      chk("R10", $sformatf("dut%0d reset outputs", d),
          {rd_en[d], wbv[d], xv[d], xcode[d], xdiz[d], xupd[d], xums[d], xvms[d]}, '0);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Directed corner cases
    do_op(32'h0000_1000, 32'h0000_0020, 1'b0, 1'b1, 5'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R6 keep vm0 rev1");
    do_op(32'h0000_1000, 32'h0000_0022, 1'b0, 1'b0, 5'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R6 swap vm0 rev0");
    do_op(32'h0000_2000, 32'h0000_0002, 1'b0, 1'b1, 5'd5, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R6 keep vm1 rev1 le1");
    do_op(32'h0000_2000, 32'h0000_0004, 1'b0, 1'b0, 5'd6, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R6 keep vm1 rev0 le0");
    do_op(32'h0000_2000, 32'h0000_0006, 1'b0, 1'b1, 5'd7, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R6 swap vm1 rev1 le0");
    do_op(32'hFFFF_FFFF, 32'h0000_0003, 1'b0, 1'b1, 5'd8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R1 wrap sum");
    do_op(32'hABCD_1234, 32'h5678_9ABE, 1'b1, 1'b0, 5'd9, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R1 extended join");
    do_op(32'h0000_3000, 32'h0000_0000, 1'b0, 1'b0, 5'd10, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R2 R3 flags ignored vm0");
    do_op(32'h0000_3000, 32'h0000_0001, 1'b0, 1'b0, 5'd11, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R2 tlb beats prot and align");
    do_op(32'h0000_3000, 32'h0000_0001, 1'b0, 1'b0, 5'd12, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R3 prot beats align");
    do_op(32'h0000_3000, 32'h0000_0000, 1'b0, 1'b0, 5'd13, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R3 prot ignored um0");
    do_op(32'h0000_3000, 32'h0000_0003, 1'b0, 1'b0, 5'd14, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R5 align keeps diz");
    do_op(32'h0000_4000, 32'h0000_0010, 1'b0, 1'b1, 5'd15, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R10 fields held on success");

    // Constrained random
    for (int i = 0; i < 400; i++) begin
      logic [31:0] ra, rb;
      logic [3:0]  fl;
      ra = $urandom; rb = $urandom; fl = 4'($urandom);
      do_op(ra, rb, fl[3] & fl[2], 1'($urandom), RW'($urandom), 1'($urandom),
            1'($urandom), (fl[1:0] == 2'b00), (fl[1:0] == 2'b01), 1'($urandom),
            "R1 random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule